// File: doc/BRIEF.md
# Transport Stream PID Filter Bank

The block sits on a byte-wide transport stream input. Each packet is 188 bytes long, and a start strobe marks its first byte, the sync byte. The block reads the 13-bit packet identifier from the second and third bytes and compares it with a bank of programmable slots. Each slot holds an identifier and an enable. Slot 0 also holds three stream-wide controls: a force-pass bit, a force-drop bit and a byte-order bit. Configuration arrives through a simple write port that uses byte offsets.

The bytes pass through a short delay line, so the decision for a packet is ready when its first byte leaves the block. Every output byte carries a pass flag. Bytes of passing packets are also packed into 32-bit words for the capture path. Register writes go into a shadow copy, and the working copy is refreshed only at the start of a packet, so a packet is never judged on a half-written setup.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset every slot is disabled and holds identifier 0x1FFF, force-drop is set, and force-pass and byte-order are clear. The outputs are idle, and every packet is dropped until software clears force-drop.
- R2: A write with `cfg_addr` equal to 4×n configures slot n. Bits 12:0 of the write data are the identifier and bit 15 is the slot enable. `cfg_addr[1:0]` is ignored.
- R3: The packet identifier is formed from bits 4:0 of byte 1 (the upper part) and all of byte 2. Bits 7:5 of byte 1 are ignored. A packet passes when an enabled slot holds its identifier.
- R4: A disabled slot never makes a packet pass, even when its identifier matches.
- R5: Force-pass (slot 0, bit 16) passes every packet with a good sync byte, whatever the slots hold.
- R6: Force-drop (slot 0, bit 13) drops every packet. It wins over force-pass and over any slot match.
- R7: A packet whose first byte is not 0x47 is dropped.
- R8: Every input byte reaches `out_data` unchanged, with its start marker, two accepted beats later. All 188 bytes of a packet carry the same `out_pass` value.
- R9: A register write takes effect from the next packet start. A write made after a packet's first byte does not change the decision for that packet.
- R10: The bytes of passing packets are packed four to a word. When byte-order (slot 0, bit 14) is 0, the first byte sits in bits 31:24. When it is 1, the first byte sits in bits 7:0. `word_valid` pulses one cycle after the fourth byte of a word is output. A dropped packet produces no words.
- R11: Slot 0 also acts as an ordinary filter slot through its identifier and enable fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_data | input | 8 | Stream byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of an output packet |
| out_data | output | 8 | Delayed stream byte |
| out_pass | output | 1 | Pass (1) or drop (0) flag for the packet this byte belongs to |
| word_valid | output | 1 | Packed word valid |
| word_data | output | 32 | Packed word of a passing packet |

## Verification
The assertions take for granted three things about the input:
- The stream begins with a start strobe.
- The strobe then recurs exactly every 188 accepted bytes.
- The first bytes of the stream are never an unaligned packet tail.

Under these assumptions, the per-packet flag and the force-drop, force-pass and sync rules hold at the decision beat. The stimulus respects this: every packet is sent whole from its strobe. The last bytes are pushed out with a short dummy packet start, and the next scenario then restarts with a fresh strobe. Register writes happen either between packets or, on purpose, on the second byte of a packet. The second case exercises the packet-boundary rule.

// File: rtl/ts_pid_filter.sv
module ts_pid_filter #(
  parameter int N_SLOTS = 8,
  parameter int PID_W   = 13,
  parameter int PKT_LEN = 188,
  parameter logic [7:0] SYNC = 8'h47,
  parameter int ADDR_W  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [7:0]  in_data,
  input  logic        cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        out_valid,
  output logic        out_sop,
  output logic [7:0]  out_data,
  output logic        out_pass,
  output logic        word_valid,
  output logic [31:0] word_data
);
  localparam int SLOT_W   = ADDR_W - 2;
  localparam int CNT_W    = $clog2(PKT_LEN);
  localparam int EN_BIT   = 15;
  localparam int BLK_BIT  = 13;
  localparam int ORD_BIT  = 14;
  localparam int ALL_BIT  = 16;
  localparam int DEC_IDX  = 2;

  logic [PID_W-1:0]   sh_pid  [N_SLOTS];
  logic [PID_W-1:0]   act_pid [N_SLOTS];
  logic [N_SLOTS-1:0] sh_en, act_en, hit;
  logic sh_block, sh_all, sh_order;
  logic act_block, act_all, act_order;

  wire [SLOT_W-1:0] wr_slot = cfg_addr[ADDR_W-1:2];
  wire wr_ok = cfg_we && (int'(wr_slot) < N_SLOTS);
  wire unused_bits = ^{cfg_wdata, cfg_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) sh_pid[i] <= '1;
      sh_en    <= '0;
      sh_block <= 1'b1;
      sh_all   <= 1'b0;
      sh_order <= 1'b0;
    end else if (wr_ok) begin
      sh_pid[wr_slot] <= cfg_wdata[PID_W-1:0];
      sh_en[wr_slot]  <= cfg_wdata[EN_BIT];
      if (wr_slot == '0) begin
        sh_block <= cfg_wdata[BLK_BIT];
        sh_order <= cfg_wdata[ORD_BIT];
        sh_all   <= cfg_wdata[ALL_BIT];
      end
    end
  end

  logic [CNT_W-1:0] cnt;
  wire  [CNT_W-1:0] idx   = in_sop ? '0 : cnt;
  wire              first = in_valid && (idx == '0);
  wire              dec_beat = in_valid && (idx == CNT_W'(DEC_IDX));
  logic sync_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sync_ok <= 1'b0;
      for (int i = 0; i < N_SLOTS; i++) act_pid[i] <= '1;
      act_en    <= '0;
      act_block <= 1'b1;
      act_all   <= 1'b0;
      act_order <= 1'b0;
    end else if (in_valid) begin
      cnt <= (idx == CNT_W'(PKT_LEN-1)) ? '0 : idx + 1'b1;
      if (first) begin
        sync_ok   <= (in_data == SYNC);
        act_pid   <= sh_pid;
        act_en    <= sh_en;
        act_block <= sh_block;
        act_all   <= sh_all;
        act_order <= sh_order;
      end
    end
  end

  logic [7:0] d0, d1;
  logic s0, s1, v0, v1;
  wire [PID_W-1:0] pid_now = {d0[PID_W-9:0], in_data};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign hit[g] = act_en[g] && (act_pid[g] == pid_now);
  end

  wire dec_now = sync_ok && !act_block && (act_all || (|hit));
  logic pass_q, order_q, out_order;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {d0, d1} <= '0;
      {s0, s1, v0, v1} <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
      out_pass  <= 1'b0;
      out_order <= 1'b0;
      pass_q    <= 1'b0;
      order_q   <= 1'b0;
    end else if (in_valid) begin
      d0 <= in_data;  s0 <= in_sop;  v0 <= 1'b1;
      d1 <= d0;       s1 <= s0;      v1 <= v0;
      out_valid <= v1;
      out_data  <= d1;
      out_sop   <= s1;
      if (dec_beat) begin
        out_pass  <= dec_now;
        out_order <= act_order;
        pass_q    <= dec_now;
        order_q   <= act_order;
      end else begin
        out_pass  <= pass_q;
        out_order <= order_q;
      end
    end else begin
      out_valid <= 1'b0;
    end
  end

  logic [1:0]  lane;
  logic [23:0] acc;
  wire  [1:0]  ln = out_sop ? 2'd0 : lane;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane <= '0;
      acc  <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (out_valid && out_pass) begin
      lane <= ln + 2'd1;
      word_valid <= (ln == 2'd3);
      if (out_order) begin
        acc <= {out_data, acc[23:8]};
        if (ln == 2'd3) word_data <= {out_data, acc};
      end else begin
        acc <= {acc[15:0], out_data};
        if (ln == 2'd3) word_data <= {acc, out_data};
      end
    end else begin
      word_valid <= 1'b0;
    end
  end

  logic last_vld, last_pass;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld  <= 1'b0;
      last_pass <= 1'b0;
    end else if (out_valid) begin
      last_vld  <= 1'b1;
      last_pass <= out_pass;
    end
  end

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop && last_vld |-> out_pass == last_pass); // R8
  AST_BLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_beat && act_block |=> !out_pass); // R6
  AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_beat && act_all && !act_block && sync_ok |=> out_pass); // R5
  AST_BAD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dec_beat && !sync_ok |=> !out_pass); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !first |=> $stable(act_block) && $stable(act_all) && $stable(act_en)); // R9
  AST_WORD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(out_valid && out_pass)); // R10
endmodule

// File: tb/test_ts_pid_filter.sv
module test_ts_pid_filter;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, cfg_we = 0;
  logic [7:0] in_data = 0;
  logic [4:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic out_valid, out_sop, out_pass, word_valid;
  logic [7:0] out_data;
  logic [31:0] word_data;

  ts_pid_filter i_ts_pid_filter (.clk, .rst_n, .in_valid, .in_sop, .in_data,
    .cfg_we, .cfg_addr, .cfg_wdata, .out_valid, .out_sop, .out_data, .out_pass,
    .word_valid, .word_data);

  always #5 clk = ~clk;

  int total = 0, bad = 0, sn = 0, np = 0, wn = 0, cyc = 0;
  bit done = 0;
  int rec_cnt [128];
  bit rec_pass [128], rec_mix [128], rec_bad [128];
  logic [31:0] wl [2048];

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_sop) begin
        np++;
        rec_cnt[np] = 0; rec_pass[np] = out_pass; rec_mix[np] = 0; rec_bad[np] = 0;
      end
      if (np > 0) begin
        if (out_pass != rec_pass[np]) rec_mix[np] = 1;
        if (rec_cnt[np] >= 3 && out_data != (8'(rec_cnt[np]) ^ 8'h5A)) rec_bad[np] = 1;
        rec_cnt[np]++;
      end
    end
    if (word_valid && wn < 2048) begin wl[wn] = word_data; wn++; end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic [12:0] pid, input logic [7:0] sync, input int nbytes,
                      input bit mw, input logic [4:0] ma, input logic [31:0] md);
    sn++;
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (k == 0);
      in_data = (k == 0) ? sync : (k == 1) ? {3'b010, pid[12:8]} :
                (k == 2) ? pid[7:0] : (8'(k) ^ 8'h5A);
      cfg_we = mw && (k == 1); cfg_addr = ma; cfg_wdata = md;
    end
    @(negedge clk); in_valid = 0; in_sop = 0; cfg_we = 0;
  endtask

  task automatic pkt(input logic [12:0] pid, input logic [7:0] sync, output int n);
    send(pid, sync, 188, 0, 0, 0); n = sn;
  endtask

  task automatic flush;
    send(13'h1FFF, 8'h47, 3, 0, 0, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_pkt(input int n, input bit exp, input string req);
    check(rec_cnt[n] == 188, "R8 byte count", rec_cnt[n], 188);
    check(!rec_mix[n], "R8 flag constant", rec_mix[n], 0);
    check(!rec_bad[n], "R8 data", rec_bad[n], 0);
    check(rec_pass[n] == exp, req, rec_pass[n], exp);
  endtask

  task automatic t_reset;
    int a, b;
    check(!out_valid && !word_valid, "R1 idle outputs", {out_valid, word_valid}, 0);
    pkt(13'h0100, 8'h47, a); flush;
    expect_pkt(a, 0, "R1 drop after reset");
    wr(5'd0, 32'h0000_1FFF);
    pkt(13'h1FFF, 8'h47, b); flush;
    expect_pkt(b, 0, "R1 slots disabled at 0x1FFF");
  endtask

  task automatic t_match;
    int a, b, c, w0;
    wr(5'd12, 32'h0000_8123);
    w0 = wn;
    pkt(13'h0123, 8'h47, a); pkt(13'h0124, 8'h47, b); flush;
    expect_pkt(a, 1, "R3 enabled match passes");
    expect_pkt(b, 0, "R3 no match drops");
    check(wn - w0 == 47, "R10 words only for passing packet", wn - w0, 47);
    wr(5'd30, 32'h0000_9ABC);
    pkt(13'h1ABC, 8'h47, c); flush;
    expect_pkt(c, 1, "R2 slot 7 via offset 28, low bits ignored");
  endtask

  task automatic t_disabled;
    int a;
    wr(5'd12, 32'h0000_0123);
    pkt(13'h0123, 8'h47, a); flush;
    expect_pkt(a, 0, "R4 disabled slot ignored");
  endtask

  task automatic t_slot0;
    int a, w0;
    wr(5'd0, 32'h0000_8042);
    w0 = wn;
    pkt(13'h0042, 8'h47, a); flush;
    expect_pkt(a, 1, "R11 slot 0 matches");
    check(wn - w0 == 47, "R10 word count", wn - w0, 47);
    check(wl[w0] == 32'h4740_4259, "R10 order 0 packing", wl[w0], 32'h4740_4259);
  endtask

  task automatic t_order;
    int a, w0;
    wr(5'd0, 32'h0000_C042);
    w0 = wn;
    pkt(13'h0042, 8'h47, a); flush;
    expect_pkt(a, 1, "R10 passes with order 1");
    check(wl[w0] == 32'h5942_4047, "R10 order 1 packing", wl[w0], 32'h5942_4047);
  endtask

  task automatic t_force;
    int a, b, c, w0;
    wr(5'd0, 32'h0001_0000);
    pkt(13'h0777, 8'h47, a); flush;
    expect_pkt(a, 1, "R5 force-pass");
    wr(5'd0, 32'h0001_2000); wr(5'd12, 32'h0000_8123);
    w0 = wn;
    pkt(13'h0777, 8'h47, b); pkt(13'h0123, 8'h47, c); flush;
    expect_pkt(b, 0, "R6 force-drop beats force-pass");
    expect_pkt(c, 0, "R6 force-drop beats match");
    check(wn == w0, "R10 no words when dropped", wn, w0);
  endtask

  task automatic t_sync;
    int a, b;
    wr(5'd0, 32'h0000_1FFF);
    pkt(13'h0123, 8'h46, a); flush;
    expect_pkt(a, 0, "R7 bad sync with match");
    wr(5'd0, 32'h0001_0000);
    pkt(13'h0555, 8'hB8, b); flush;
    expect_pkt(b, 0, "R7 bad sync with force-pass");
  endtask

  task automatic t_boundary;
    int a, b;
    wr(5'd0, 32'h0000_1FFF); wr(5'd12, 32'h0000_8123);
    send(13'h0123, 8'h47, 188, 1, 5'd12, 32'h0000_0123); a = sn;
    pkt(13'h0123, 8'h47, b); flush;
    expect_pkt(a, 1, "R9 mid-packet write deferred");
    expect_pkt(b, 0, "R9 write applies next packet");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_match;
    t_disabled;
    t_slot0;
    t_order;
    t_force;
    t_sync;
    t_boundary;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule